// File: doc/BRIEF.md
# Signed Halfword Multiply-Accumulate Unit

This unit carries out four signed DSP multiply forms for a processor execute stage. Three of the forms take a signed 16-bit slice from each operand. The fourth takes the whole first operand and one 16-bit slice of the second. Each operation can add an accumulator, of either 32 or 64 bits, depending on the form.

The caller presents the following together with a valid strobe:

- an operation code
- two half-select bits
- two 32-bit operands
- a low accumulator word and a high accumulator word

One clock later the unit returns a registered result with an output valid. The result is a low word and, for the 64-bit form, a high word. When a 32-bit accumulate overflows as a signed add, the unit also raises a one-cycle pulse for setting a sticky overflow flag. The flag itself lives outside the unit. The sum is never saturated: the wrapped value is always written.

Top module: `hmac_unit`

## Requirements
- R1: `sel_x_i`=1 selects bits 31:16 of `opa_i` and `sel_x_i`=0 selects bits 15:0. `sel_y_i` selects from `opb_i` in the same way. Each selected slice is sign-extended as a two's-complement value.
- R2: With `op_i`=0 (halfword multiply), `res_lo_o` is the signed 32-bit product of the two slices and `ovf_set_o` stays 0.
- R3: With `op_i`=1 (halfword multiply, 32-bit accumulate), `res_lo_o` is the product plus `acc_lo_i`, wrapped to 32 bits. `ovf_set_o` pulses when that signed addition overflows.
- R4: With `op_i`=2 (word by halfword), the signed 32-bit `opa_i` is multiplied by the `sel_y_i` slice of `opb_i`. When `sel_x_i`=1, `res_lo_o` is bits 47:16 of the 48-bit product and `ovf_set_o` stays 0.
- R5: With `op_i`=2 and `sel_x_i`=0, `res_lo_o` is bits 47:16 of that product plus `acc_lo_i`, wrapped to 32 bits. `ovf_set_o` pulses on signed overflow of that addition.
- R6: With `op_i`=3 (64-bit accumulate), {`res_hi_o`,`res_lo_o`} = {`acc_hi_i`,`acc_lo_i`} plus the sign-extended halfword product, modulo 2^64. `ovf_set_o` never pulses in this form.
- R7: `out_valid_o` equals `in_valid_i` from one clock earlier, and the results belong to that input. `ovf_set_o` is only ever 1 while `out_valid_o` is 1.
- R8: Reset clears `out_valid_o`, `ovf_set_o` and both result words. In a cycle with no valid input, the result words keep their values.
- R9: For the three 32-bit forms (`op_i` 0 to 2), `res_hi_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation request strobe |
| op_i | input | 2 | Operation: 0 mul16, 1 mla16, 2 word by half, 3 64-bit accumulate |
| sel_x_i | input | 1 | Half select for `opa_i`; accumulate disable in the word form |
| sel_y_i | input | 1 | Half select for `opb_i` |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| acc_lo_i | input | 32 | Accumulator, low word |
| acc_hi_i | input | 32 | Accumulator, high word |
| out_valid_o | output | 1 | Result valid |
| res_lo_o | output | 32 | Result, low word |
| res_hi_o | output | 32 | Result, high word (64-bit form only) |
| ovf_set_o | output | 1 | Sticky overflow set pulse |

## Verification
Every result word and the overflow pulse is due exactly one rising edge after the cycle in which `in_valid_i` was high. The bench drives each request on a falling edge and lowers the valid on the next falling edge. It reads all outputs at that second falling edge, which is half a period after the single register stage has loaded. On the falling edge after that, it confirms that `out_valid_o` and `ovf_set_o` have dropped and that the result words have held. This places every comparison in the one cycle where the answer must be present.

// File: rtl/hmac_pkg.sv
package hmac_pkg;
  typedef enum logic [1:0] {
    OP_MUL16 = 2'd0,
    OP_MLA16 = 2'd1,
    OP_MULW  = 2'd2,
    OP_MLAL  = 2'd3
  } hmac_op_e;
endpackage

// File: rtl/hmac_half_sel.sv
module hmac_half_sel #(
  parameter int W = 32
) (
  input  logic [W-1:0]   word_i,
  input  logic           hi_i,
  output logic [W/2-1:0] half_o
);
  localparam int H = W / 2;
  assign half_o = hi_i ? word_i[W-1:H] : word_i[H-1:0];
endmodule

// File: rtl/hmac_sadd.sv
module hmac_sadd #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);
  assign sum_o = a_i + b_i;
  // Signed overflow: operands agree in sign, sum does not.
  assign ovf_o = (a_i[W-1] == b_i[W-1]) && (sum_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/hmac_datapath.sv
module hmac_datapath
  import hmac_pkg::*;
#(
  parameter int W = 32
) (
  input  hmac_op_e     op_i,
  input  logic         sel_x_i,
  input  logic         sel_y_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic [W-1:0] acc_lo_i,
  input  logic [W-1:0] acc_hi_i,
  output logic [W-1:0] res_lo_o,
  output logic [W-1:0] res_hi_o,
  output logic         ovf_o
);
  localparam int H  = W / 2;
  localparam int WH = W + H;
  localparam int DW = 2 * W;

  logic [H-1:0]  half_a, half_b;
  logic [W-1:0]  ha_ext, hb_ext, prod_hh, prod_wh_top, add_a, sum;
  logic [WH-1:0] wa_ext, hbw_ext, prod_wh;
  logic [DW-1:0] acc_long, prod_long, long_sum;
  logic          sum_ovf;

  hmac_half_sel #(.W(W)) u_sel_a (.word_i(opa_i), .hi_i(sel_x_i), .half_o(half_a));
  hmac_half_sel #(.W(W)) u_sel_b (.word_i(opb_i), .hi_i(sel_y_i), .half_o(half_b));

  // Low bits of a two's-complement product are sign-agnostic once operands are extended.
  assign ha_ext  = {{H{half_a[H-1]}}, half_a};
  assign hb_ext  = {{H{half_b[H-1]}}, half_b};
  assign prod_hh = ha_ext * hb_ext;

  assign wa_ext      = {{H{opa_i[W-1]}}, opa_i};
  assign hbw_ext     = {{W{half_b[H-1]}}, half_b};
  assign prod_wh     = wa_ext * hbw_ext;
  assign prod_wh_top = prod_wh[WH-1:H];

  // One shared 32-bit adder serves both 32-bit accumulate forms.
  assign add_a = (op_i == OP_MULW) ? prod_wh_top : prod_hh;
  hmac_sadd #(.W(W)) u_add (.a_i(add_a), .b_i(acc_lo_i), .sum_o(sum), .ovf_o(sum_ovf));

  assign acc_long  = {acc_hi_i, acc_lo_i};
  assign prod_long = {{W{prod_hh[W-1]}}, prod_hh};
  assign long_sum  = acc_long + prod_long;

  always_comb begin
    res_lo_o = '0;
    res_hi_o = '0;
    ovf_o    = 1'b0;
    unique case (op_i)
      OP_MUL16: res_lo_o = prod_hh;
      OP_MLA16: begin
        res_lo_o = sum;
        ovf_o    = sum_ovf;
      end
      OP_MULW: begin
        if (sel_x_i) begin
          res_lo_o = prod_wh_top;
        end else begin
          res_lo_o = sum;
          ovf_o    = sum_ovf;
        end
      end
      OP_MLAL: begin
        res_lo_o = long_sum[W-1:0];
        res_hi_o = long_sum[DW-1:W];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hmac_unit.sv
module hmac_unit
  import hmac_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic [1:0]   op_i,
  input  logic         sel_x_i,
  input  logic         sel_y_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic [W-1:0] acc_lo_i,
  input  logic [W-1:0] acc_hi_i,
  output logic         out_valid_o,
  output logic [W-1:0] res_lo_o,
  output logic [W-1:0] res_hi_o,
  output logic         ovf_set_o
);
  hmac_op_e     op_d, op_q;
  logic [W-1:0] dp_lo, dp_hi;
  logic         dp_ovf;

  assign op_d = hmac_op_e'(op_i);

  hmac_datapath #(.W(W)) u_dp (
    .op_i    (op_d),
    .sel_x_i (sel_x_i),
    .sel_y_i (sel_y_i),
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .acc_lo_i(acc_lo_i),
    .acc_hi_i(acc_hi_i),
    .res_lo_o(dp_lo),
    .res_hi_o(dp_hi),
    .ovf_o   (dp_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      ovf_set_o   <= 1'b0;
      res_lo_o    <= '0;
      res_hi_o    <= '0;
      op_q        <= OP_MUL16;
    end else begin
      out_valid_o <= in_valid_i;
      ovf_set_o   <= in_valid_i & dp_ovf;
      if (in_valid_i) begin
        res_lo_o <= dp_lo;
        res_hi_o <= dp_hi;
        op_q     <= op_d;
      end
    end
  end

  assert_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == $past(in_valid_i));
  assert_ovf_qual_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_set_o |-> out_valid_o);
  assert_mul16_no_ovf_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && op_q == OP_MUL16) |-> !ovf_set_o);
  assert_mlal_no_ovf_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && op_q == OP_MLAL) |-> !ovf_set_o);
  assert_hi_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && op_q != OP_MLAL) |-> (res_hi_o == '0));
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(res_lo_o) && $stable(res_hi_o)));
endmodule

// File: tb/test_hmac_unit.sv
`timescale 1ns/1ps
module test_hmac_unit;
  localparam time CLK = 8ns;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] al;
    logic [31:0] ah;
  } stim_t;

  localparam stim_t TBL [8] = '{
    '{2'd0, 32'h8000_8000, 32'h8000_7FFF, 32'h0,         32'h0},
    '{2'd0, 32'h1234_FFFF, 32'hFFFE_0003, 32'h0,         32'h0},
    '{2'd1, 32'h8000_8000, 32'h8000_8000, 32'h4000_0000, 32'h0},
    '{2'd1, 32'h0001_FFFF, 32'h7FFF_0002, 32'h8000_0000, 32'h0},
    '{2'd2, 32'h8000_0000, 32'h8000_7FFF, 32'h7FFF_FFFF, 32'h0},
    '{2'd2, 32'h7FFF_FFFF, 32'h7FFF_8000, 32'h8000_0001, 32'h0},
    '{2'd3, 32'h8000_8000, 32'h8000_8000, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{2'd3, 32'hFFFF_0001, 32'h0001_FFFF, 32'h0,         32'h8000_0000}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic        sel_x_i = 1'b0, sel_y_i = 1'b0;
  logic [31:0] opa_i = '0, opb_i = '0, acc_lo_i = '0, acc_hi_i = '0;
  logic        out_valid_o, ovf_set_o;
  logic [31:0] res_lo_o, res_hi_o;

  int n_chk = 0;
  int n_err = 0;

  hmac_unit i_hmac_unit (.*);

  always #(CLK/2) clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  // Behavioural model: returns {ovf, hi, lo}.
  function automatic logic [64:0] model(input logic [1:0] op, input logic sx, input logic sy,
                                        input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] al, input logic [31:0] ah);
    longint ha, hb, wa, acc, p, s;
    logic [63:0] r;
    logic ovf;
    ha  = longint'($signed(sx ? a[31:16] : a[15:0]));
    hb  = longint'($signed(sy ? b[31:16] : b[15:0]));
    wa  = longint'($signed(a));
    acc = longint'($signed(al));
    ovf = 1'b0;
    r   = '0;
    case (op)
      2'd0: begin p = ha * hb; r = {32'h0, p[31:0]}; end
      2'd1: begin
        s = ha * hb + acc;
        r = {32'h0, s[31:0]};
        ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      2'd2: begin
        p = (wa * hb) >>> 16;
        if (sx) r = {32'h0, p[31:0]};
        else begin
          s = p + acc;
          r = {32'h0, s[31:0]};
          ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        end
      end
      default: begin s = longint'({ah, al}) + ha * hb; r = s; end
    endcase
    return {ovf, r};
  endfunction

  // Issue one request; outputs due at the next falling edge (one posedge later).
  task automatic issue(input logic [1:0] op, input logic sx, input logic sy,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] al, input logic [31:0] ah,
                       output logic [64:0] got);
    @(negedge clk_i);
    in_valid_i = 1'b1; op_i = op; sel_x_i = sx; sel_y_i = sy;
    opa_i = a; opb_i = b; acc_lo_i = al; acc_hi_i = ah;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk("R7 out_valid after request", {63'h0, out_valid_o}, 64'h1);
    got = {ovf_set_o, res_hi_o, res_lo_o};
  endtask

  task automatic run_model(input string tag, input logic [1:0] op, input logic sx, input logic sy,
                           input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] al, input logic [31:0] ah);
    logic [64:0] got, exp;
    exp = model(op, sx, sy, a, b, al, ah);
    issue(op, sx, sy, a, b, al, ah, got);
    chk({tag, " result"}, got[63:0], exp[63:0]);
    chk({tag, " ovf pulse"}, {63'h0, got[64]}, {63'h0, exp[64]});
  endtask

  task automatic run_hand(input string tag, input logic [1:0] op, input logic sx, input logic sy,
                          input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] al, input logic [31:0] ah,
                          input logic [63:0] exp_r, input logic exp_o);
    logic [64:0] got;
    issue(op, sx, sy, a, b, al, ah, got);
    chk({tag, " result"}, got[63:0], exp_r);
    chk({tag, " ovf pulse"}, {63'h0, got[64]}, {63'h0, exp_o});
  endtask

  initial begin
    #(CLK * 150000);
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk_i);
    // R8: reset state
    chk("R8 reset out_valid", {63'h0, out_valid_o}, 64'h0);
    chk("R8 reset result", {res_hi_o, res_lo_o}, 64'h0);
    chk("R8 reset ovf", {63'h0, ovf_set_o}, 64'h0);
    rst_ni = 1'b1;

    // Table walk, every select combination per vector (R1..R6, R9)
    foreach (TBL[i]) begin
      for (int s = 0; s < 4; s++) begin
        run_model($sformatf("R1-sel%0d vec%0d op%0d", s, i, TBL[i].op),
                  TBL[i].op, s[1], s[0], TBL[i].a, TBL[i].b, TBL[i].al, TBL[i].ah);
      end
    end

    // R1: half selection, hand values
    run_hand("R1 low*low",  2'd0, 1'b0, 1'b0, 32'h0003_0005, 32'h0007_0002, '0, '0, 64'd10, 1'b0);
    run_hand("R1 high*high", 2'd0, 1'b1, 1'b1, 32'h0003_0005, 32'h0007_0002, '0, '0, 64'd21, 1'b0);
    // R2: both operands 0x8000
    run_hand("R2 min*min", 2'd0, 1'b0, 1'b1, 32'h0000_8000, 32'h8000_0000, '0, '0, 64'h4000_0000, 1'b0);
    // R3: accumulate overflow wraps and flags
    run_hand("R3 ovf wrap", 2'd1, 1'b0, 1'b0, 32'h0000_8000, 32'h0000_8000, 32'h4000_0000, '0,
             64'h8000_0000, 1'b1);
    // R4: word by half, no accumulate
    run_hand("R4 top bits", 2'd2, 1'b1, 1'b0, 32'h8000_0000, 32'h0000_8000, 32'h1234_5678, '0,
             64'h4000_0000, 1'b0);
    // R5: word by half with accumulate overflow
    run_hand("R5 acc ovf", 2'd2, 1'b0, 1'b0, 32'h7FFF_FFFF, 32'h0000_7FFF, 32'h7FFF_FFFF, '0,
             64'hBFFF_7FFE, 1'b1);
    // R6: carry out of bit 63 discarded, no flag
    run_hand("R6 carry drop", 2'd3, 1'b0, 1'b0, 32'h1, 32'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
             64'h0, 1'b0);
    // R9: high word zero for 32-bit op after a 64-bit op left it nonzero
    run_hand("R6 set hi", 2'd3, 1'b0, 1'b0, 32'h1, 32'h1, 32'h0, 32'h5555_0000,
             64'h5555_0000_0000_0001, 1'b0);
    run_hand("R9 hi cleared", 2'd1, 1'b0, 1'b0, 32'h2, 32'h3, 32'h1, 32'hFFFF_FFFF, 64'd7, 1'b0);

    // R8 hold / R7 pulse drop: overflow request, then idle cycle with changed inputs
    run_hand("R3 pre-hold", 2'd1, 1'b0, 1'b0, 32'h0000_8000, 32'h0000_8000, 32'h4000_0000, '0,
             64'h8000_0000, 1'b1);
    held = {res_hi_o, res_lo_o};
    opa_i = 32'hDEAD_BEEF; acc_lo_i = 32'h1; op_i = 2'd3;
    @(negedge clk_i);
    chk("R7 valid drops", {63'h0, out_valid_o}, 64'h0);
    chk("R7 ovf drops", {63'h0, ovf_set_o}, 64'h0);
    chk("R8 result held", {res_hi_o, res_lo_o}, held);

    // R8: asynchronous reset mid-run
    run_hand("R2 pre-reset", 2'd0, 1'b1, 1'b0, 32'h0002_0000, 32'h0000_0003, '0, '0, 64'd6, 1'b0);
    #(CLK/4) rst_ni = 1'b0;
    #1;
    chk("R8 async reset valid", {63'h0, out_valid_o}, 64'h0);
    chk("R8 async reset result", {res_hi_o, res_lo_o}, 64'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    summary();
  end
endmodule